// File: doc/BRIEF.md
# Autopoll and Service-Request Poll Scheduler

This block decides which "talk register 0" command a serial peripheral-bus sequencer sends when nothing else asks for the bus, and which one it sends after a device signals that it needs service. A 16-bit participation mask lists the device addresses that take part. The block looks at the last command byte the sequencer put on the bus. From that byte and the mask it chooses a target address and offers one command byte over a valid/ready handshake.

There are two triggers. When the sequencer reports that the bus is idle and no user request is waiting, the block polls the lowest listed address. It skips this poll if the previous command was already a register-0 talk to a listed device, because the sequencer repeats that command by itself. When a service request arrives, the block polls the next listed address above the one last addressed, wrapping to the lowest listed address. It does this whether or not user requests are pending, so the poll goes ahead of them. A service request that arrives while a command is still on offer is remembered and served once that command has been taken.

Top module: `autopoll_sched`

## Requirements
- R1: While reset is held and on the first cycle after it, `cmd_valid` is low.
- R2: Every offered command carries the target address in bits 7:4 and the register-0 talk code 4'hC in bits 3:0.
- R3: Mask bit 0 is ignored. Address 0 is never polled, and a mask with only bit 0 set behaves as an empty mask.
- R4: On a service request, the target is the lowest listed address strictly above `last_cmd[7:4]`.
- R5: On a service request with no listed address above `last_cmd[7:4]`, the target is the lowest listed address.
- R6: With an empty mask, neither trigger produces a command, and a service request seen then is discarded.
- R7: When `bus_idle` is high and `last_cmd` is not a talk to a listed address (bits 3:0 differ from 4'hC, or the mask bit for bits 7:4 is clear), the lowest listed address is polled.
- R8: When `bus_idle` is high and `last_cmd` is 4'hC in bits 3:0 with a listed address in bits 7:4, no command is offered.
- R9: A service request produces a command even when `bus_idle` is low. When both triggers are present in the same cycle, the service-request target is offered.
- R10: A command becomes valid on the clock edge after its trigger. It then holds its byte until it is accepted (`cmd_valid` and `cmd_ready` both high), and `cmd_valid` is low for the cycle after acceptance. Only one command is outstanding at a time.
- R11: A service request that arrives while a command is on offer is kept. It is served on the cycle after the current command is dropped, using the `last_cmd` and mask values present at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_mask | input | 16 | Bit n lists device address n for polling |
| last_cmd | input | 8 | Last command byte the sequencer transmitted |
| srq_pulse | input | 1 | One-cycle pulse: a device requested service |
| bus_idle | input | 1 | Bus idle with no pending user request |
| cmd_ready | input | 1 | Sequencer accepts the offered command |
| cmd_valid | output | 1 | A poll command is on offer |
| cmd_byte | output | 8 | Offered command byte |

## Verification
The bench builds the block with its default parameters: 4 address bits, 4 opcode bits and the talk code 4'hC. These defaults put the full 16-address mask and the real 8-bit command layout within reach. With this width, random masks and last-command bytes reach the wrap-around edge at address 15, masks that hold only the ignored bit 0, and last commands that target a listed device. Directed sequences hold a command against a stalled `cmd_ready` while the inputs change, and queue a service request behind it.

// File: rtl/autopoll_sched_pkg.sv
package autopoll_sched_pkg;

   typedef enum logic [1:0] {
      LAUNCH_NONE = 2'd0,
      LAUNCH_SRQ  = 2'd1,
      LAUNCH_IDLE = 2'd2
   } launch_e;

endpackage

// File: rtl/lsb_prienc.sv
module lsb_prienc #(
   parameter int N     = 16,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic [IDX_W-1:0] idx,
   output logic             hit
);

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
      hit = |req;
   end

endmodule

// File: rtl/poll_target_sel.sv
module poll_target_sel #(
   parameter int ADDR_W = 4,
   localparam int NDEV  = 1 << ADDR_W
) (
   input  logic [NDEV-1:0]   mask_eff,
   input  logic [ADDR_W-1:0] ref_addr,
   output logic [ADDR_W-1:0] srq_addr,
   output logic [ADDR_W-1:0] low_addr,
   output logic              any_listed
);

   logic [NDEV-1:0]   above;
   logic [ADDR_W-1:0] above_idx;
   logic              above_hit;

   for (genvar g = 0; g < NDEV; g++) begin : g_above
      assign above[g] = (ADDR_W'(g) > ref_addr);
   end

   lsb_prienc #(.N(NDEV), .IDX_W(ADDR_W)) above_enc_i (
      .req (mask_eff & above),
      .idx (above_idx),
      .hit (above_hit)
   );

   lsb_prienc #(.N(NDEV), .IDX_W(ADDR_W)) low_enc_i (
      .req (mask_eff),
      .idx (low_addr),
      .hit (any_listed)
   );

   assign srq_addr = above_hit ? above_idx : low_addr;

endmodule

// File: rtl/autopoll_sched.sv
module autopoll_sched
   import autopoll_sched_pkg::*;
#(
   parameter int          ADDR_W  = 4,
   parameter int          OP_W    = 4,
   parameter logic [OP_W-1:0] TALK_OP = 4'hC,
   localparam int         NDEV    = 1 << ADDR_W,
   localparam int         CMD_W   = ADDR_W + OP_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NDEV-1:0]  poll_mask,
   input  logic [CMD_W-1:0] last_cmd,
   input  logic             srq_pulse,
   input  logic             bus_idle,
   input  logic             cmd_ready,
   output logic             cmd_valid,
   output logic [CMD_W-1:0] cmd_byte
);

   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr_w
      $error("autopoll_sched: ADDR_W must lie in 1..8");
   end
   if (OP_W < 1) begin : g_bad_op_w
      $error("autopoll_sched: OP_W must be at least 1");
   end

   logic [NDEV-1:0]   mask_eff;
   logic [ADDR_W-1:0] last_addr;
   logic [OP_W-1:0]   last_op;
   logic [ADDR_W-1:0] srq_addr;
   logic [ADDR_W-1:0] low_addr;
   logic              any_listed;
   logic              idle_covered;
   logic              srq_want;
   logic              idle_want;
   logic              srq_pend;
   launch_e           launch;

   assign mask_eff  = poll_mask & ~NDEV'(1);
   assign last_addr = last_cmd[CMD_W-1 -: ADDR_W];
   assign last_op   = last_cmd[OP_W-1:0];

   poll_target_sel #(.ADDR_W(ADDR_W)) sel_i (
      .mask_eff   (mask_eff),
      .ref_addr   (last_addr),
      .srq_addr   (srq_addr),
      .low_addr   (low_addr),
      .any_listed (any_listed)
   );

   assign idle_covered = (last_op == TALK_OP) && mask_eff[last_addr];
   assign srq_want     = (srq_pulse || srq_pend) && any_listed;
   assign idle_want    = bus_idle && any_listed && !idle_covered;

   always_comb begin
      launch = LAUNCH_NONE;
      if (!cmd_valid) begin
         if (srq_want)       launch = LAUNCH_SRQ;
         else if (idle_want) launch = LAUNCH_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_byte  <= '0;
         srq_pend  <= 1'b0;
      end else begin
         if (!any_listed)               srq_pend <= 1'b0;
         else if (launch == LAUNCH_SRQ) srq_pend <= 1'b0;
         else if (srq_pulse)            srq_pend <= 1'b1;

         if (cmd_valid && cmd_ready) begin
            cmd_valid <= 1'b0;
         end else if (launch != LAUNCH_NONE) begin
            cmd_valid <= 1'b1;
            cmd_byte  <= {(launch == LAUNCH_SRQ) ? srq_addr : low_addr, TALK_OP};
         end
      end
   end

endmodule

// File: rtl/autopoll_sched_chk.sv
module autopoll_sched_chk #(
   parameter int          ADDR_W  = 4,
   parameter int          OP_W    = 4,
   parameter logic [OP_W-1:0] TALK_OP = 4'hC,
   localparam int         NDEV    = 1 << ADDR_W,
   localparam int         CMD_W   = ADDR_W + OP_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NDEV-1:0]  poll_mask,
   input logic             srq_pulse,
   input logic             bus_idle,
   input logic             srq_pend,
   input logic             cmd_ready,
   input logic             cmd_valid,
   input logic [CMD_W-1:0] cmd_byte
);

   // R10
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_byte));

   // R10
   drop_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready |=> !cmd_valid);

   // R2
   talk_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> cmd_byte[OP_W-1:0] == TALK_OP);

   // R3
   no_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> cmd_byte[CMD_W-1 -: ADDR_W] != '0);

   // R6
   empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_valid) |-> $past(|(poll_mask & ~NDEV'(1))));

   // R9
   launch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_valid) |-> $past(bus_idle || srq_pulse || srq_pend));

endmodule

bind autopoll_sched autopoll_sched_chk #(
   .ADDR_W  (ADDR_W),
   .OP_W    (OP_W),
   .TALK_OP (TALK_OP)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .poll_mask (poll_mask),
   .srq_pulse (srq_pulse),
   .bus_idle  (bus_idle),
   .srq_pend  (srq_pend),
   .cmd_ready (cmd_ready),
   .cmd_valid (cmd_valid),
   .cmd_byte  (cmd_byte)
);

// File: tb/autopoll_sched_tb_top.sv
module autopoll_sched_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] poll_mask = '0;
   logic [7:0]  last_cmd = '0;
   logic        srq_pulse = 1'b0;
   logic        bus_idle = 1'b0;
   logic        cmd_ready = 1'b0;
   logic        cmd_valid;
   logic [7:0]  cmd_byte;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   autopoll_sched dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .poll_mask (poll_mask),
      .last_cmd  (last_cmd),
      .srq_pulse (srq_pulse),
      .bus_idle  (bus_idle),
      .cmd_ready (cmd_ready),
      .cmd_valid (cmd_valid),
      .cmd_byte  (cmd_byte)
   );

   task automatic check(input string tag, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   function automatic logic [3:0] lowest(input logic [15:0] m);
      logic [3:0] r = 4'd0;
      for (int i = 15; i >= 1; i--) if (m[i]) r = 4'(i);
      return r;
   endfunction

   function automatic bit has_above(input logic [15:0] m, input logic [7:0] last);
      bit r = 1'b0;
      for (int i = 1; i < 16; i++) if (m[i] && i > int'(last[7:4])) r = 1'b1;
      return r;
   endfunction

   function automatic logic [7:0] srq_cmd(input logic [15:0] mask, input logic [7:0] last);
      logic [15:0] m = mask & 16'hFFFE;
      logic [3:0]  a = lowest(m);
      for (int i = 15; i >= 1; i--) if (m[i] && i > int'(last[7:4])) a = 4'(i);
      return {a, 4'hC};
   endfunction

   function automatic bit idle_need(input logic [15:0] mask, input logic [7:0] last);
      logic [15:0] m = mask & 16'hFFFE;
      return (m != 0) && !(last[3:0] == 4'hC && m[last[7:4]]);
   endfunction

   task automatic accept_and_drain(input string tag);
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      check(tag, cmd_valid, 0);
   endtask

   // One trigger: sets inputs, checks the offered command, then drains it.
   task automatic trigger(input logic [15:0] m, input logic [7:0] last,
                          input bit srq, input bit idle, input string tag);
      logic [15:0] me = m & 16'hFFFE;
      bit          ev;
      logic [7:0]  eb;
      poll_mask = m; last_cmd = last; srq_pulse = srq; bus_idle = idle;
      @(negedge clk);
      srq_pulse = 1'b0; bus_idle = 1'b0;
      ev = (srq && me != 0) || (idle && idle_need(m, last));
      eb = (srq && me != 0) ? srq_cmd(m, last) : {lowest(me), 4'hC};
      check({tag, " valid"}, cmd_valid, ev);
      if (ev) check({tag, " byte"}, cmd_byte, eb);
      accept_and_drain("R10 drop");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1d2c3b4a));
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 in reset", cmd_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", cmd_valid, 0);

      // R3 bit 0 alone is an empty mask
      trigger(16'h0001, 8'h30, 1'b1, 1'b1, "R3 only bit0");
      // R3 wrap never lands on address 0
      trigger(16'h0003, 8'hFC, 1'b1, 1'b0, "R3 wrap skips 0");
      // R4 next above
      trigger(16'h00A4, 8'h3C, 1'b1, 1'b0, "R4 above");
      // R5 wrap
      trigger(16'h00A4, 8'h7C, 1'b1, 1'b0, "R5 wrap");
      // R6 empty mask
      trigger(16'h0000, 8'h10, 1'b1, 1'b1, "R6 empty");
      // R7 idle poll: last was not talk0
      trigger(16'h00A4, 8'h5D, 1'b0, 1'b1, "R7 idle");
      // R8 idle covered by talk0 to listed
      trigger(16'h00A4, 8'h5C, 1'b0, 1'b1, "R8 covered");
      // R9 both: service request wins (0x5C, not 0x2C)
      trigger(16'h00A4, 8'h30, 1'b1, 1'b1, "R9 both");

      // R10 hold and R11 queued request
      poll_mask = 16'h00A4; last_cmd = 8'h20; srq_pulse = 1'b1;
      @(negedge clk);
      srq_pulse = 1'b0;
      check("R10 launch valid", cmd_valid, 1);
      check("R10 launch byte", cmd_byte, 8'h5C);
      last_cmd = 8'h7C; poll_mask = 16'hFFFF;
      @(negedge clk);
      check("R10 held byte", cmd_byte, 8'h5C);
      srq_pulse = 1'b1;
      @(negedge clk);
      srq_pulse = 1'b0;
      check("R10 held valid", cmd_valid, 1);
      check("R10 held byte 2", cmd_byte, 8'h5C);
      accept_and_drain("R10 gap");
      @(negedge clk);
      check("R11 queued valid", cmd_valid, 1);
      check("R11 queued byte", cmd_byte, 8'h8C);
      accept_and_drain("R11 drain");

      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [15:0] m = 16'($urandom);
         logic [7:0]  l = 8'($urandom);
         int          sel = int'($urandom % 3);
         bit          s = (sel != 1);
         bit          i = (sel != 0);
         string       tag;
         if ($urandom % 8 == 0) m = '0;
         else if ($urandom % 8 == 0) m = 16'h0001;
         if ($urandom % 2 == 1) l[3:0] = 4'hC;
         if ((m & 16'hFFFE) == 0)          tag = "R6 rand";
         else if (s && i)                  tag = "R9 rand";
         else if (s)                       tag = has_above(m & 16'hFFFE, l) ? "R4 rand" : "R5 rand";
         else                              tag = idle_need(m, l) ? "R7 rand" : "R8 rand";
         trigger(m, l, s, i, tag);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule